// File: doc/BRIEF.md
# Multi-Mode 8-Bit Waveform Timer

An 8-bit counter paired with two compare channels that drive one waveform pin each. A 3-bit mode field selects the counting pattern: free-running count, clear-on-compare, single-slope fast PWM, or dual-slope phase-correct PWM. The wrap point, called TOP here, is either the all-ones value or compare value A. Each channel has a 2-bit output mode that says how its pin reacts to a compare match and, in the PWM modes, to the counter reaching its end points. The counter advances on every clock.

The compare values are written into buffers through a synchronous register port. Each buffer is copied into the active compare register at a point that depends on the mode. In the count and clear-on-compare modes the copy happens at once. In fast PWM it happens as the counter wraps from TOP to zero. In phase-correct PWM it happens when the counter turns around at TOP. The block produces a one-cycle overflow pulse and a one-cycle match pulse per channel.

The counter is a two-state machine. The states are `DIR_UP` and `DIR_DOWN`, and only phase-correct PWM uses `DIR_DOWN`:
- The transition UP→DOWN happens at TOP when TOP > 1.
- The transition DOWN→UP happens when the count leaves 1, or at once if a non-phase mode is selected.
- Every other mode stays in `DIR_UP`, and the counter wraps to zero after TOP.

Top module: `pwm8_timer`

## Requirements
- R1: While reset is held, `count` is 0, both wave pins are 0, all three pulses are 0 and every register reads back 0.
- R2: Register map:
  - Address 0 holds channel A output mode in [7:6], channel B output mode in [5:4], mode bits 1:0 in [1:0]. Bits [3:2] always read 0.
  - Address 1 holds mode bit 2 in bit 0. Its other bits read 0.
  - Addresses 2 and 3 read back the written compare buffers A and B.
- R3: Modes 000 (count) and 010 (clear-on-compare) step by +1 per clock. Mode 000 wraps after 0xFF. Mode 010 wraps to 0 on the clock after the count equals compare A. In both modes, written compare values take effect on the next clock.
- R4: Fast PWM counts 0..TOP and then returns to 0, so the period is TOP+1. Mode 011 uses TOP=0xFF and mode 111 uses TOP=compare A. New compare values become active only on the clock where the count leaves TOP.
- R5: Phase-correct PWM runs 0,1..TOP,TOP-1..1,0 without repeating an end point, so the period is 2·TOP. Mode 001 uses TOP=0xFF and mode 101 uses TOP=compare A. New compare values become active at the turnaround at TOP.
- R6: `ovf_pulse` is high for one cycle:
  - after the count shows 0xFF, in modes 000, 010 and 011;
  - after the count shows TOP, in mode 111;
  - after the count shows 0 while counting up, in modes 001 and 101.
- R7: `hit_a` and `hit_b` are high for exactly the one cycle after `count` equals the active compare value of that channel.
- R8: In modes 000 and 010, a match drives the pin as follows: 00 = low, 01 = toggle, 10 = clear, 11 = set. The pin changes on the clock after the match.
- R9: Fast PWM with output mode 10 sets the pin when the counter leaves TOP and clears it after a match at compare value K, giving K+1 high cycles per period. Output mode 11 is the inverse. Output modes 00 and 01 hold the pin low.
- R10: Fast PWM with compare value = TOP and output mode 1x ignores the match and applies only the wrap action. Mode 10 keeps the pin high and mode 11 keeps it low.
- R11: Phase-correct PWM with output mode 10 clears the pin on an up-count match and sets it on a down-count match, where a match at 0 counts as up. This gives 2·K high cycles per period. Output mode 11 is the inverse.
- R12: Phase-correct PWM with compare value = TOP and output mode 1x ignores the match and applies the down-count action at TOP. Mode 10 keeps the pin high and mode 11 keeps it low.
- R13: The reserved modes 100 and 110 behave like mode 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counter advances every edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| count | output | 8 | Current counter value |
| ovf_pulse | output | 1 | One-cycle overflow pulse |
| hit_a | output | 1 | One-cycle channel A match pulse |
| hit_b | output | 1 | One-cycle channel B match pulse |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |

## Verification
Two functions can fall in the same cycle: the reload of a buffered compare value and the TOP/BOTTOM special action that depends on that same value. In modes 101 and 111, compare A is itself TOP, so channel A meets the compare-equals-TOP rule in exactly the cycle where A is reloaded. The bench provokes this with table rows in those modes where compare A is TOP, and it judges each row by the measured period and the high-cycle count on each pin. A second collision, a compare write landing mid-period before the update point, is provoked directly. It is judged by the absence of an early match pulse and by the match appearing one period later.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

    typedef enum logic [1:0] {
        WG_COUNT = 2'd0,
        WG_FAST  = 2'd1,
        WG_PHASE = 2'd2
    } wg_kind_t;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_state_t;

    typedef struct packed {
        wg_kind_t kind;
        logic     top_from_a;
        logic     ovf_at_top;
        logic     upd_immediate;
    } mode_cfg_t;

    function automatic mode_cfg_t decode_mode(input logic [2:0] m);
        mode_cfg_t c;
        unique case (m)
            3'b000:  c = '{WG_COUNT, 1'b0, 1'b0, 1'b1};
            3'b001:  c = '{WG_PHASE, 1'b0, 1'b0, 1'b0};
            3'b010:  c = '{WG_COUNT, 1'b1, 1'b0, 1'b1};
            3'b011:  c = '{WG_FAST,  1'b0, 1'b0, 1'b0};
            3'b100:  c = '{WG_COUNT, 1'b0, 1'b0, 1'b1};
            3'b101:  c = '{WG_PHASE, 1'b1, 1'b0, 1'b0};
            3'b110:  c = '{WG_COUNT, 1'b0, 1'b0, 1'b1};
            3'b111:  c = '{WG_FAST,  1'b1, 1'b1, 1'b0};
            default: c = '{WG_COUNT, 1'b0, 1'b0, 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pwm8_regs.sv
module pwm8_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_addr,
    input  logic [W-1:0] buf_a,
    input  logic [W-1:0] buf_b,
    output logic [W-1:0] rd_data,
    output logic [2:0]   mode_o,
    output logic [1:0]   com_a_o,
    output logic [1:0]   com_b_o,
    output logic         wr_cmp_a,
    output logic         wr_cmp_b
);
    localparam logic [1:0] ADDR_CTL0 = 2'd0;
    localparam logic [1:0] ADDR_CTL1 = 2'd1;
    localparam logic [1:0] ADDR_CMPA = 2'd2;
    localparam logic [1:0] ADDR_CMPB = 2'd3;

    logic [2:0] mode_q;
    logic [1:0] com_a_q, com_b_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            com_a_q <= '0;
            com_b_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTL0) begin
                com_a_q     <= wr_data[7:6];
                com_b_q     <= wr_data[5:4];
                mode_q[1:0] <= wr_data[1:0];
            end
            if (wr_addr == ADDR_CTL1) begin
                mode_q[2] <= wr_data[0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTL0: begin
                rd_data[7:6] = com_a_q;
                rd_data[5:4] = com_b_q;
                rd_data[1:0] = mode_q[1:0];
            end
            ADDR_CTL1: rd_data[0] = mode_q[2];
            ADDR_CMPA: rd_data = buf_a;
            ADDR_CMPB: rd_data = buf_b;
            default:   rd_data = '0;
        endcase
    end

    assign mode_o   = mode_q;
    assign com_a_o  = com_a_q;
    assign com_b_o  = com_b_q;
    assign wr_cmp_a = wr_en && (wr_addr == ADDR_CMPA);
    assign wr_cmp_b = wr_en && (wr_addr == ADDR_CMPB);

endmodule

// File: rtl/pwm8_core.sv
module pwm8_core
    import pwm8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mode_cfg_t    cfg,
    input  logic [W-1:0] top_src,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] top_o,
    output logic         at_top_o,
    output logic         up_o,
    output logic         upd_now_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    dir_state_t   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d, top;
    logic         at_top, ovf_evt, is_phase;

    always_comb begin
        top      = cfg.top_from_a ? top_src : MAXV;
        at_top   = (cnt_q == top);
        is_phase = (cfg.kind == WG_PHASE);
    end

    // next-state and next-count logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + ONE;
        unique case (state_q)
            DIR_UP: begin
                if (at_top) begin
                    if (is_phase && top > ONE) begin
                        state_d = DIR_DOWN;
                        cnt_d   = top - ONE;
                    end else begin
                        cnt_d = '0;
                    end
                end
            end
            DIR_DOWN: begin
                if (!is_phase) begin
                    state_d = DIR_UP;
                end else begin
                    cnt_d = cnt_q - ONE;
                    if (cnt_q <= ONE) begin
                        state_d = DIR_UP;
                        if (cnt_q == '0) cnt_d = '0;
                    end
                end
            end
            default: state_d = DIR_UP;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DIR_UP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        if (is_phase)
            ovf_evt = (state_q == DIR_UP) && (cnt_q == '0);
        else if (cfg.ovf_at_top)
            ovf_evt = at_top;
        else
            ovf_evt = (cnt_q == MAXV);

        if (cfg.upd_immediate)
            upd_now_o = 1'b1;
        else if (is_phase)
            upd_now_o = (state_q == DIR_UP) && at_top;
        else
            upd_now_o = at_top;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_o <= 1'b0;
        else        ovf_o <= ovf_evt;
    end

    assign cnt_o    = cnt_q;
    assign top_o    = top;
    assign at_top_o = at_top;
    assign up_o     = (state_q == DIR_UP);

    // R5: dual-slope counting moves by exactly one per clock
    a_r5_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (is_phase && top > ONE) |=>
        (cnt_q == W'($past(cnt_q) + ONE) || cnt_q == W'($past(cnt_q) - ONE)));

    // R4: fast PWM returns to zero right after TOP
    a_r4_fast_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.kind == WG_FAST && at_top) |=> (cnt_q == '0));

    // R6: in single-slope modes the overflow pulse coincides with count zero
    a_r6_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !is_phase && $past(cfg.kind) != WG_PHASE) |-> (cnt_q == '0));

endmodule

// File: rtl/pwm8_channel.sv
module pwm8_channel
    import pwm8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_cmp,
    input  logic [W-1:0] wr_val,
    input  logic [1:0]   out_mode,
    input  wg_kind_t     kind,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] top,
    input  logic         at_top,
    input  logic         count_up,
    input  logic         upd_now,
    output logic [W-1:0] buf_o,
    output logic [W-1:0] act_o,
    output logic         hit_o,
    output logic         wave_o
);
    logic [W-1:0] buf_q, act_q;
    logic         match, cmp_is_top, wave_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            if (wr_cmp)  buf_q <= wr_val;
            if (upd_now) act_q <= wr_cmp ? wr_val : buf_q;
        end
    end

    always_comb begin
        match      = (cnt == act_q);
        cmp_is_top = (act_q == top);
        wave_d     = wave_o;
        unique case (kind)
            WG_COUNT: begin
                if (out_mode == 2'b00)
                    wave_d = 1'b0;
                else if (match)
                    wave_d = (out_mode == 2'b01) ? ~wave_o : out_mode[0];
            end
            WG_FAST: begin
                if (!out_mode[1]) begin
                    wave_d = 1'b0;
                end else begin
                    if (match && !cmp_is_top) wave_d = out_mode[0];
                    if (at_top)               wave_d = ~out_mode[0];
                end
            end
            WG_PHASE: begin
                if (!out_mode[1])
                    wave_d = 1'b0;
                else if (cmp_is_top) begin
                    if (at_top && count_up) wave_d = ~out_mode[0];
                end else if (match)
                    wave_d = count_up ? out_mode[0] : ~out_mode[0];
            end
            default: wave_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_o <= 1'b0;
            hit_o  <= 1'b0;
        end else begin
            wave_o <= wave_d;
            hit_o  <= match;
        end
    end

    assign buf_o = buf_q;
    assign act_o = act_q;

    // R4 / R5: buffered modes keep the active value between update points
    a_r4_buffer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != WG_COUNT && !upd_now) |=> $stable(act_q));

    // R10: compare equal to TOP leaves the pin untouched away from the wrap
    a_r10_top_match_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WG_FAST && out_mode[1] && cmp_is_top && !at_top) |=> $stable(wave_o));

endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer
    import pwm8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_addr,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] count,
    output logic         ovf_pulse,
    output logic         hit_a,
    output logic         hit_b,
    output logic         wave_a,
    output logic         wave_b
);
    localparam int NCH = 2;

    logic [2:0]   mode;
    mode_cfg_t    cfg;
    logic [1:0]   com   [NCH];
    logic         wr_cmp[NCH];
    logic [W-1:0] bufv  [NCH];
    logic [W-1:0] actv  [NCH];
    logic         hit   [NCH];
    logic         wave  [NCH];
    logic [W-1:0] cnt, top;
    logic         at_top, up, upd_now;

    assign cfg = decode_mode(mode);

    pwm8_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .buf_a(bufv[0]), .buf_b(bufv[1]),
        .rd_data(rd_data), .mode_o(mode),
        .com_a_o(com[0]), .com_b_o(com[1]),
        .wr_cmp_a(wr_cmp[0]), .wr_cmp_b(wr_cmp[1])
    );

    pwm8_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .top_src(actv[0]),
        .cnt_o(cnt), .top_o(top), .at_top_o(at_top), .up_o(up),
        .upd_now_o(upd_now), .ovf_o(ovf_pulse)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        pwm8_channel #(.W(W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .wr_cmp(wr_cmp[ch]), .wr_val(wr_data), .out_mode(com[ch]),
            .kind(cfg.kind), .cnt(cnt), .top(top), .at_top(at_top),
            .count_up(up), .upd_now(upd_now),
            .buf_o(bufv[ch]), .act_o(actv[ch]),
            .hit_o(hit[ch]), .wave_o(wave[ch])
        );
    end

    assign count  = cnt;
    assign hit_a  = hit[0];
    assign hit_b  = hit[1];
    assign wave_a = wave[0];
    assign wave_b = wave[1];

    // R7: a match pulse never lasts two cycles while the count keeps moving
    a_r7_hit_single: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && cnt != $past(cnt)) |=> !hit_a || (cnt == actv[0]) || $past(cnt == actv[0]));

endmodule

// File: tb/pwm8_timer_bench.sv
module pwm8_timer_bench;

    typedef struct packed {
        logic [2:0]  mode;
        logic [1:0]  ca;
        logic [1:0]  cb;
        logic [7:0]  oa;
        logic [7:0]  ob;
        logic [15:0] per;
        logic [15:0] ovf;
        logic [15:0] hia;
        logic [15:0] hib;
        logic [3:0]  rq_per;
        logic [3:0]  rq_wave;
    } vec_t;

    // mode, outA, outB, cmpA, cmpB, period, ovf/period, highA, highB, req(period), req(wave)
    localparam vec_t VEC [13] = '{
        '{3'b011, 2'd2, 2'd3, 8'd64,  8'd200, 16'd256, 16'd1, 16'd65,  16'd55,  4'd4,  4'd9 },  // R4 R9
        '{3'b011, 2'd2, 2'd2, 8'd255, 8'd0,   16'd256, 16'd1, 16'd256, 16'd1,   4'd4,  4'd10},  // R10
        '{3'b011, 2'd3, 2'd2, 8'd255, 8'd10,  16'd256, 16'd1, 16'd0,   16'd11,  4'd4,  4'd10},  // R10
        '{3'b111, 2'd2, 2'd2, 8'd99,  8'd30,  16'd100, 16'd1, 16'd100, 16'd31,  4'd4,  4'd10},  // R10
        '{3'b111, 2'd3, 2'd2, 8'd49,  8'd80,  16'd50,  16'd1, 16'd0,   16'd50,  4'd4,  4'd10},  // R10
        '{3'b001, 2'd2, 2'd3, 8'd100, 8'd200, 16'd510, 16'd1, 16'd200, 16'd110, 4'd5,  4'd11},  // R5 R11
        '{3'b001, 2'd2, 2'd3, 8'd255, 8'd255, 16'd510, 16'd1, 16'd510, 16'd0,   4'd5,  4'd12},  // R12
        '{3'b001, 2'd2, 2'd2, 8'd0,   8'd1,   16'd510, 16'd1, 16'd0,   16'd2,   4'd5,  4'd11},  // R11
        '{3'b101, 2'd2, 2'd2, 8'd60,  8'd20,  16'd120, 16'd1, 16'd120, 16'd40,  4'd5,  4'd12},  // R12
        '{3'b101, 2'd3, 2'd3, 8'd60,  8'd59,  16'd120, 16'd1, 16'd0,   16'd2,   4'd5,  4'd12},  // R12
        '{3'b010, 2'd0, 2'd0, 8'd99,  8'd0,   16'd100, 16'd0, 16'd0,   16'd0,   4'd3,  4'd8 },  // R3 R8
        '{3'b000, 2'd0, 2'd0, 8'd5,   8'd6,   16'd256, 16'd1, 16'd0,   16'd0,   4'd3,  4'd8 },  // R3 R6
        '{3'b100, 2'd0, 2'd0, 8'd5,   8'd6,   16'd256, 16'd1, 16'd0,   16'd0,   4'd13, 4'd13}   // R13
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data, count;
    logic       ovf_pulse, hit_a, hit_b, wave_a, wave_b;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pwm8_timer u_pwm8_timer (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .count(count), .ovf_pulse(ovf_pulse),
        .hit_a(hit_a), .hit_b(hit_b),
        .wave_a(wave_a), .wave_b(wave_b)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_count(input logic [7:0] v);
        @(negedge clk);
        while (count !== v) @(negedge clk);
    endtask

    task automatic configure(input logic [2:0] m, input logic [1:0] ca, input logic [1:0] cb,
                             input logic [7:0] oa, input logic [7:0] ob);
        reg_write(2'd2, oa);
        reg_write(2'd3, ob);
        reg_write(2'd1, {7'd0, m[2]});
        reg_write(2'd0, {ca, cb, 2'b00, m[1:0]});
        repeat (3) wait_count(8'd0);
    endtask

    initial begin
        logic [7:0] rd;
        int per, na, nb, no, s1, s2;
        int seq[6] = '{1, 2, 3, 2, 1, 0};

        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk("R1 count", count, 0);
        chk("R1 wave_a", wave_a, 0);
        chk("R1 wave_b", wave_b, 0);
        chk("R1 pulses", {ovf_pulse, hit_a, hit_b}, 0);
        for (int a = 0; a < 4; a++) begin
            reg_read(a[1:0], rd);
            chk($sformatf("R1 read addr %0d", a), rd, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reserved bits read zero, fields read back
        reg_write(2'd0, 8'hFF);
        reg_read(2'd0, rd);
        chk("R2 control 0 readback", rd, 8'hF3);
        reg_write(2'd1, 8'hFF);
        reg_read(2'd1, rd);
        chk("R2 control 1 readback", rd, 8'h01);
        reg_write(2'd2, 8'h5A);
        reg_read(2'd2, rd);
        chk("R2 compare A readback", rd, 8'h5A);

        // table of steady-state waveform vectors
        for (int i = 0; i < 13; i++) begin
            configure(VEC[i].mode, VEC[i].ca, VEC[i].cb, VEC[i].oa, VEC[i].ob);
            per = 0; na = 0; nb = 0; no = 0;
            do begin
                na += int'(wave_a); nb += int'(wave_b); no += int'(ovf_pulse);
                per++;
                @(negedge clk);
            end while (count != 8'd0 && per < 2000);
            chk($sformatf("R%0d row %0d period", VEC[i].rq_per, i), per, int'(VEC[i].per));
            chk($sformatf("R6 row %0d overflow pulses", i), no, int'(VEC[i].ovf));
            chk($sformatf("R%0d row %0d high A", VEC[i].rq_wave, i), na, int'(VEC[i].hia));
            chk($sformatf("R%0d row %0d high B", VEC[i].rq_wave, i), nb, int'(VEC[i].hib));
        end

        // R7: match pulse lands in the cycle after the count equals compare A
        configure(3'b000, 2'd0, 2'd0, 8'd40, 8'd0);
        wait_count(8'd40);
        chk("R7 hit_a at match cycle", hit_a, 0);
        @(negedge clk);
        chk("R7 hit_a one cycle later", hit_a, 1);
        @(negedge clk);
        chk("R7 hit_a after pulse", hit_a, 0);

        // R6: overflow instant in mode 111 and in mode 101
        configure(3'b111, 2'd0, 2'd0, 8'd99, 8'd0);
        wait_count(8'd99);
        chk("R6 fast-A ovf at TOP cycle", ovf_pulse, 0);
        @(negedge clk);
        chk("R6 fast-A ovf at next count", ovf_pulse, 1);
        configure(3'b101, 2'd0, 2'd0, 8'd60, 8'd0);
        wait_count(8'd0);
        chk("R6 phase ovf at bottom cycle", ovf_pulse, 0);
        @(negedge clk);
        chk("R6 phase ovf after bottom", ovf_pulse, 1);

        // R4: compare B written mid-period waits for the wrap
        configure(3'b011, 2'd0, 2'd0, 8'd0, 8'd100);
        wait_count(8'd150);
        reg_write(2'd3, 8'd200);
        reg_read(2'd3, rd);
        chk("R2 compare B buffer readback", rd, 200);
        s1 = 0;
        while (count != 8'd0) begin
            s1 += int'(hit_b);
            @(negedge clk);
        end
        chk("R4 no early match before wrap", s1, 0);
        wait_count(8'd201);
        chk("R4 new compare active after wrap", hit_b, 1);

        // R3: compare A write takes effect at once in clear-on-compare
        configure(3'b010, 2'd0, 2'd0, 8'd200, 8'd0);
        wait_count(8'd50);
        reg_write(2'd2, 8'd100);
        wait_count(8'd100);
        @(negedge clk);
        chk("R3 immediate TOP change wrap", count, 0);

        // R8: toggle, clear and set on match
        configure(3'b010, 2'd1, 2'd0, 8'd9, 8'd0);
        wait_count(8'd5);
        s1 = int'(wave_a);
        wait_count(8'd5);
        s2 = int'(wave_a);
        chk("R8 toggle changes each period", s1 ^ s2, 1);
        reg_write(2'd0, 8'b10_00_00_10);
        wait_count(8'd5);
        chk("R8 clear on match", wave_a, 0);
        reg_write(2'd0, 8'b11_00_00_10);
        wait_count(8'd5);
        chk("R8 set on match", wave_a, 1);

        // R5: dual-slope sequence with TOP 3
        configure(3'b101, 2'd0, 2'd0, 8'd3, 8'd0);
        wait_count(8'd0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk($sformatf("R5 step %0d", k), count, seq[k]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 150000 cycles expected fewer");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule